// File: doc/BRIEF.md
# Host Adapter Command Sequencer

This block is the control state machine that walks one queued command block at a time through its life on a host adapter. It accepts a command from the input side and fetches the command's scatter-gather vector through the host DMA engine. It then issues the command on the target bus and waits for the target's answer. After that it either runs the data phase or retires the command. The DMA datapath, the target-bus protocol and the queue storage sit outside. The sequencer only raises requests and strobes and watches the counts and status codes those neighbours report back.

Commands enter through a valid/ready pair. `start_ready_o` is high only while the sequencer is idle. A command is taken on a clock edge where both `start_valid_i` and `start_ready_o` are high. A source that sees ready low must hold its command and valid until ready returns. On that edge the command index, its target byte and its control byte are captured. While a command is in flight, new commands are back-pressured.

The sequencer also keeps hardware statistics of the time from command acceptance to the target's first answer: a running minimum, a running maximum and a sum. It also counts target disconnects. It produces a retry-delay value for the activation timer that follows it. That delay is long after a busy answer and short after an error or a disconnect.

Top module: `cmd_seq_fsm`

## Requirements
- R1: `start_ready_o` is 1 exactly while the sequencer is idle. A command is captured on an edge with `start_valid_i` and `start_ready_o` both high, and `start_ready_o` is 0 from the next cycle on.
- R2: In the vector-fetch and data states, `dma_req_o` follows `remaining_nz_i`, and it is 0 in every other state. The vector fetch ends only on an edge where `remaining_nz_i` is 0 and `dma_outstanding_i` is 0.
- R3: If `reconnect_pend_i` is 1 on the edge that ends the vector fetch, the sequencer returns to idle. It raises none of `cmd_issue_o`, `q_pop_o`, `pend_we_o` or `retire_o`.
- R4: Otherwise `cmd_issue_o` pulses for one cycle after that edge. `q_pop_o` pulses in the same cycle if and only if `q_nonempty_i` is 1 and `q_head_i` equals the captured command index.
- R5: `pend_we_o` pulses together with `cmd_issue_o` when bit 5 (tag enable) of the captured control byte is 0. The pulse carries `pend_tgt_o` = the upper nibble of the captured target byte and `pend_idx_o` = the command index.
- R6: Status codes are: 0 active, 1 connect, 2 complete, 3 disconnect, 4 busy, 5 error. Codes 6 and 7 are treated as active. In the response state, an active status keeps the sequencer polling. Complete retires the command with no delay load, and connect moves to the data state.
- R7: A busy response (4) retires the command and loads a delay of BUSY_MULT x READ_CYC cycles (150 by default) through `delay_load_o`/`delay_val_o`.
- R8: An error response (5) retires the command and loads a delay of FAST_CYC (2). A disconnect response (3) goes to idle without retiring, sets bit 2 of `ctrl_o`, increments `disc_cnt_o` and loads a delay of FAST_CYC.
- R9: After reset, `lat_min_o` is all ones and `lat_max_o` and `lat_sum_o` are 0. On every non-active response in the response state, the latency L updates the minimum, the maximum and the sum. L is the number of clock edges from the accepting edge to the response edge.
- R10: In the data state the sequencer waits until `remaining_nz_i` and `dma_outstanding_i` are both 0. A connect status (1) then keeps it polling. Complete retires the command. Disconnect returns to idle with a FAST_CYC delay, no retire and no change to `disc_cnt_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid_i | input | 1 | Command offered |
| start_ready_o | output | 1 | Sequencer idle, command may be taken |
| cmd_idx_i | input | IDX_W | Index of the offered command |
| cmd_tcl_i | input | 8 | Target/channel/unit byte of the command |
| cmd_ctrl_i | input | 8 | Control byte of the command |
| reconnect_pend_i | input | 1 | A reconnect request is queued |
| dma_outstanding_i | input | CNT_W | DMA data returns still outstanding |
| remaining_nz_i | input | 1 | DMA length still to be requested is nonzero |
| tgt_status_i | input | 3 | Target status code |
| q_nonempty_i | input | 1 | Input queue holds at least one entry |
| q_head_i | input | IDX_W | Command index at the input queue head |
| dma_req_o | output | 1 | Request one more host DMA transfer |
| cmd_issue_o | output | 1 | Issue the command on the target bus (pulse) |
| q_pop_o | output | 1 | Pop the input queue head (pulse) |
| pend_we_o | output | 1 | Record an untagged command as pending (pulse) |
| pend_tgt_o | output | 4 | Target number of the pending record |
| pend_idx_o | output | IDX_W | Command index of the pending record |
| retire_o | output | 1 | Retire the command (pulse) |
| delay_load_o | output | 1 | Load the activation delay timer (pulse) |
| delay_val_o | output | DLY_W | Delay value in cycles |
| ctrl_o | output | 8 | Captured control byte with disconnect mark |
| disc_cnt_o | output | DCNT_W | Number of response-state disconnects |
| lat_min_o | output | LAT_W | Minimum response latency |
| lat_max_o | output | LAT_W | Maximum response latency |
| lat_sum_o | output | SUM_W | Sum of response latencies |
| err_o | output | 1 | Sticky illegal-state flag |

## Verification
Two events can fall on the same edge: the final DMA data return that ends the vector fetch, and a pending reconnect. The bench drives the outstanding count to zero and raises the reconnect flag at the same falling edge. It then checks in the following cycle that no issue, pop, pending-record or retire strobe appeared and that the sequencer is ready again. The other coincidence is the issue strobe with the queue pop and the pending record. The bench runs matching and mismatching queue heads, and tagged and untagged control bytes, and checks that each strobe is present or absent in the very cycle of `cmd_issue_o`.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_VEC  = 3'd1,
    ST_RESP = 3'd2,
    ST_DATA = 3'd3
  } seq_state_e;

  typedef enum logic [2:0] {
    TS_ACTIVE     = 3'd0,
    TS_CONNECT    = 3'd1,
    TS_COMPLETE   = 3'd2,
    TS_DISCONNECT = 3'd3,
    TS_BUSY       = 3'd4,
    TS_ERROR      = 3'd5
  } tgt_status_e;
endpackage

// File: rtl/cmd_seq_lat.sv
module cmd_seq_lat #(
  parameter int LAT_W = 8,
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             busy_i,
  input  logic             resp_i,
  output logic [LAT_W-1:0] lat_min_o,
  output logic [LAT_W-1:0] lat_max_o,
  output logic [SUM_W-1:0] lat_sum_o
);
  localparam logic [LAT_W-1:0] LAT_SAT = '1;

  logic [LAT_W-1:0] age_q;

  // age counts edges since acceptance, saturating at all ones
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q <= '0;
    end else if (accept_i) begin
      age_q <= LAT_W'(1);
    end else if (busy_i && age_q != LAT_SAT) begin
      age_q <= age_q + LAT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_min_o <= LAT_SAT;
      lat_max_o <= '0;
      lat_sum_o <= '0;
    end else if (resp_i) begin
      if (age_q < lat_min_o) lat_min_o <= age_q;
      if (age_q > lat_max_o) lat_max_o <= age_q;
      lat_sum_o <= lat_sum_o + SUM_W'(age_q);
    end
  end
endmodule

// File: rtl/cmd_seq_core.sv
module cmd_seq_core
  import cmd_seq_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 4,
  parameter int DLY_W     = 12,
  parameter int DCNT_W    = 8,
  parameter int FAST_CYC  = 2,
  parameter int READ_CYC  = 3,
  parameter int BUSY_MULT = 50,
  parameter int TAG_BIT   = 5,
  parameter int DISC_BIT  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid_i,
  output logic              start_ready_o,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [7:0]        cmd_tcl_i,
  input  logic [7:0]        cmd_ctrl_i,
  input  logic              reconnect_pend_i,
  input  logic [CNT_W-1:0]  dma_outstanding_i,
  input  logic              remaining_nz_i,
  input  logic [2:0]        tgt_status_i,
  input  logic              q_nonempty_i,
  input  logic [IDX_W-1:0]  q_head_i,
  output logic              dma_req_o,
  output logic              cmd_issue_o,
  output logic              q_pop_o,
  output logic              pend_we_o,
  output logic [3:0]        pend_tgt_o,
  output logic [IDX_W-1:0]  pend_idx_o,
  output logic              retire_o,
  output logic              delay_load_o,
  output logic [DLY_W-1:0]  delay_val_o,
  output logic [7:0]        ctrl_o,
  output logic [DCNT_W-1:0] disc_cnt_o,
  output logic              err_o,
  output logic              accept_o,
  output logic              resp_o,
  output seq_state_e        state_o
);
  localparam logic [DLY_W-1:0] FAST_DLY = DLY_W'(FAST_CYC);
  localparam logic [DLY_W-1:0] BUSY_DLY = DLY_W'(BUSY_MULT * READ_CYC);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [7:0]       tcl_q;
  logic [7:0]       ctrl_q;
  logic             xfer_idle;
  tgt_status_e      st;
  logic             st_known;

  assign st        = tgt_status_e'(tgt_status_i);
  assign st_known  = (tgt_status_i != 3'd0) && (tgt_status_i <= 3'd5);
  assign xfer_idle = !remaining_nz_i && (dma_outstanding_i == '0);

  assign start_ready_o = (state_q == ST_IDLE);
  assign accept_o      = start_valid_i && start_ready_o;
  assign resp_o        = (state_q == ST_RESP) && st_known;
  assign dma_req_o     = remaining_nz_i && (state_q == ST_VEC || state_q == ST_DATA);
  assign pend_tgt_o    = tcl_q[7:4];
  assign pend_idx_o    = idx_q;
  assign ctrl_o        = ctrl_q;
  assign state_o       = state_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      idx_q        <= '0;
      tcl_q        <= '0;
      ctrl_q       <= '0;
      cmd_issue_o  <= 1'b0;
      q_pop_o      <= 1'b0;
      pend_we_o    <= 1'b0;
      retire_o     <= 1'b0;
      delay_load_o <= 1'b0;
      delay_val_o  <= '0;
      disc_cnt_o   <= '0;
      err_o        <= 1'b0;
    end else begin
      cmd_issue_o  <= 1'b0;
      q_pop_o      <= 1'b0;
      pend_we_o    <= 1'b0;
      retire_o     <= 1'b0;
      delay_load_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_valid_i) begin
            idx_q   <= cmd_idx_i;
            tcl_q   <= cmd_tcl_i;
            ctrl_q  <= cmd_ctrl_i;
            state_q <= ST_VEC;
          end
        end
        ST_VEC: begin
          if (xfer_idle) begin
            if (reconnect_pend_i) begin
              state_q <= ST_IDLE;
            end else begin
              cmd_issue_o <= 1'b1;
              q_pop_o     <= q_nonempty_i && (q_head_i == idx_q);
              pend_we_o   <= !ctrl_q[TAG_BIT];
              state_q     <= ST_RESP;
            end
          end
        end
        ST_RESP: begin
          case (st)
            TS_CONNECT:  state_q <= ST_DATA;
            TS_COMPLETE: begin
              retire_o <= 1'b1;
              state_q  <= ST_IDLE;
            end
            TS_ERROR: begin
              retire_o     <= 1'b1;
              delay_load_o <= 1'b1;
              delay_val_o  <= FAST_DLY;
              state_q      <= ST_IDLE;
            end
            TS_BUSY: begin
              retire_o     <= 1'b1;
              delay_load_o <= 1'b1;
              delay_val_o  <= BUSY_DLY;
              state_q      <= ST_IDLE;
            end
            TS_DISCONNECT: begin
              ctrl_q[DISC_BIT] <= 1'b1;
              disc_cnt_o       <= disc_cnt_o + DCNT_W'(1);
              delay_load_o     <= 1'b1;
              delay_val_o      <= FAST_DLY;
              state_q          <= ST_IDLE;
            end
            default: state_q <= ST_RESP;
          endcase
        end
        ST_DATA: begin
          if (xfer_idle) begin
            if (st == TS_COMPLETE) begin
              retire_o <= 1'b1;
              state_q  <= ST_IDLE;
            end else if (st == TS_DISCONNECT) begin
              delay_load_o <= 1'b1;
              delay_val_o  <= FAST_DLY;
              state_q      <= ST_IDLE;
            end
          end
        end
        default: begin
          err_o   <= 1'b1;
          state_q <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
  import cmd_seq_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 4,
  parameter int DLY_W     = 12,
  parameter int DCNT_W    = 8,
  parameter int LAT_W     = 8,
  parameter int SUM_W     = 16,
  parameter int FAST_CYC  = 2,
  parameter int READ_CYC  = 3,
  parameter int BUSY_MULT = 50
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid_i,
  output logic              start_ready_o,
  input  logic [IDX_W-1:0]  cmd_idx_i,
  input  logic [7:0]        cmd_tcl_i,
  input  logic [7:0]        cmd_ctrl_i,
  input  logic              reconnect_pend_i,
  input  logic [CNT_W-1:0]  dma_outstanding_i,
  input  logic              remaining_nz_i,
  input  logic [2:0]        tgt_status_i,
  input  logic              q_nonempty_i,
  input  logic [IDX_W-1:0]  q_head_i,
  output logic              dma_req_o,
  output logic              cmd_issue_o,
  output logic              q_pop_o,
  output logic              pend_we_o,
  output logic [3:0]        pend_tgt_o,
  output logic [IDX_W-1:0]  pend_idx_o,
  output logic              retire_o,
  output logic              delay_load_o,
  output logic [DLY_W-1:0]  delay_val_o,
  output logic [7:0]        ctrl_o,
  output logic [DCNT_W-1:0] disc_cnt_o,
  output logic [LAT_W-1:0]  lat_min_o,
  output logic [LAT_W-1:0]  lat_max_o,
  output logic [SUM_W-1:0]  lat_sum_o,
  output logic              err_o
);
  logic       accept_w;
  logic       resp_w;
  seq_state_e state_w;

  cmd_seq_core #(
    .IDX_W(IDX_W), .CNT_W(CNT_W), .DLY_W(DLY_W), .DCNT_W(DCNT_W),
    .FAST_CYC(FAST_CYC), .READ_CYC(READ_CYC), .BUSY_MULT(BUSY_MULT),
    .TAG_BIT(5), .DISC_BIT(2)
  ) core_i (
    .clk(clk), .rst_n(rst_n),
    .start_valid_i(start_valid_i), .start_ready_o(start_ready_o),
    .cmd_idx_i(cmd_idx_i), .cmd_tcl_i(cmd_tcl_i), .cmd_ctrl_i(cmd_ctrl_i),
    .reconnect_pend_i(reconnect_pend_i), .dma_outstanding_i(dma_outstanding_i),
    .remaining_nz_i(remaining_nz_i), .tgt_status_i(tgt_status_i),
    .q_nonempty_i(q_nonempty_i), .q_head_i(q_head_i),
    .dma_req_o(dma_req_o), .cmd_issue_o(cmd_issue_o), .q_pop_o(q_pop_o),
    .pend_we_o(pend_we_o), .pend_tgt_o(pend_tgt_o), .pend_idx_o(pend_idx_o),
    .retire_o(retire_o), .delay_load_o(delay_load_o), .delay_val_o(delay_val_o),
    .ctrl_o(ctrl_o), .disc_cnt_o(disc_cnt_o), .err_o(err_o),
    .accept_o(accept_w), .resp_o(resp_w), .state_o(state_w)
  );

  cmd_seq_lat #(.LAT_W(LAT_W), .SUM_W(SUM_W)) lat_i (
    .clk(clk), .rst_n(rst_n),
    .accept_i(accept_w), .busy_i(state_w != ST_IDLE), .resp_i(resp_w),
    .lat_min_o(lat_min_o), .lat_max_o(lat_max_o), .lat_sum_o(lat_sum_o)
  );
endmodule

// File: rtl/cmd_seq_chk.sv
module cmd_seq_chk
  import cmd_seq_pkg::*;
#(
  parameter int IDX_W = 4,
  parameter int CNT_W = 4,
  parameter int DLY_W = 12,
  parameter int READ_CYC = 3,
  parameter int BUSY_MULT = 50
) (
  input logic             clk,
  input logic             rst_n,
  input seq_state_e       state_w,
  input logic             reconnect_pend_i,
  input logic             remaining_nz_i,
  input logic [CNT_W-1:0] dma_outstanding_i,
  input logic             dma_req_o,
  input logic             cmd_issue_o,
  input logic             q_pop_o,
  input logic             pend_we_o,
  input logic             retire_o,
  input logic             delay_load_o,
  input logic [DLY_W-1:0] delay_val_o
);
  localparam logic [DLY_W-1:0] BUSY_DLY = DLY_W'(BUSY_MULT * READ_CYC);

  // R3: reconnect at end of vector fetch aborts without issuing
  a_r3_abort_no_issue: assert property (@(posedge clk) disable iff (!rst_n)
    (state_w == ST_VEC && !remaining_nz_i && dma_outstanding_i == '0 && reconnect_pend_i)
    |=> (!cmd_issue_o && !q_pop_o && state_w == ST_IDLE));

  // R4: a pop only ever accompanies an issue
  a_r4_pop_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
    q_pop_o |-> cmd_issue_o);

  // R5: a pending record only ever accompanies an issue
  a_r5_pend_with_issue: assert property (@(posedge clk) disable iff (!rst_n)
    pend_we_o |-> cmd_issue_o);

  // R2: DMA requests only in fetch or data state
  a_r2_dma_in_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req_o |-> (state_w == ST_VEC || state_w == ST_DATA));

  // R6: issue and retire never share a cycle
  a_r6_issue_retire_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_issue_o, retire_o}));

  // R7: the long delay is only loaded together with a retire
  a_r7_busy_delay_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (delay_load_o && delay_val_o == BUSY_DLY) |-> retire_o);
endmodule

bind cmd_seq_fsm cmd_seq_chk #(
  .IDX_W(IDX_W), .CNT_W(CNT_W), .DLY_W(DLY_W),
  .READ_CYC(READ_CYC), .BUSY_MULT(BUSY_MULT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .state_w(state_w),
  .reconnect_pend_i(reconnect_pend_i), .remaining_nz_i(remaining_nz_i),
  .dma_outstanding_i(dma_outstanding_i), .dma_req_o(dma_req_o),
  .cmd_issue_o(cmd_issue_o), .q_pop_o(q_pop_o), .pend_we_o(pend_we_o),
  .retire_o(retire_o), .delay_load_o(delay_load_o), .delay_val_o(delay_val_o)
);

// File: tb/cmd_seq_fsm_tb_top.sv
module cmd_seq_fsm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid_i = 1'b0;
  logic        start_ready_o;
  logic [3:0]  cmd_idx_i = '0;
  logic [7:0]  cmd_tcl_i = '0;
  logic [7:0]  cmd_ctrl_i = '0;
  logic        reconnect_pend_i = 1'b0;
  logic [3:0]  dma_outstanding_i = '0;
  logic        remaining_nz_i = 1'b0;
  logic [2:0]  tgt_status_i = 3'd0;
  logic        q_nonempty_i = 1'b0;
  logic [3:0]  q_head_i = '0;
  logic        dma_req_o, cmd_issue_o, q_pop_o, pend_we_o, retire_o, delay_load_o, err_o;
  logic [3:0]  pend_tgt_o, pend_idx_o;
  logic [11:0] delay_val_o;
  logic [7:0]  ctrl_o, disc_cnt_o, lat_min_o, lat_max_o;
  logic [15:0] lat_sum_o;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int acc_cyc = 0;
  int exp_min = 255;
  int exp_max = 0;
  int exp_sum = 0;
  int exp_disc = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cmd_seq_fsm dut_i (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic note_resp();
    int l;
    l = cyc - acc_cyc;
    if (l < exp_min) exp_min = l;
    if (l > exp_max) exp_max = l;
    exp_sum += l;
  endtask

  task automatic chk_lat(input string tag);
    chk({tag, " R9 lat_min"}, int'(lat_min_o), exp_min);
    chk({tag, " R9 lat_max"}, int'(lat_max_o), exp_max);
    chk({tag, " R9 lat_sum"}, int'(lat_sum_o), exp_sum);
  endtask

  // offer a command, leave the sequencer in the vector-fetch state
  task automatic start_cmd(input logic [3:0] idx, input logic [7:0] tcl, input logic [7:0] ctrl);
    step();
    chk("R1 ready idle", int'(start_ready_o), 1);
    start_valid_i = 1'b1; cmd_idx_i = idx; cmd_tcl_i = tcl; cmd_ctrl_i = ctrl;
    remaining_nz_i = 1'b1; dma_outstanding_i = 4'd1;
    step();
    start_valid_i = 1'b0; cmd_idx_i = 4'hF;
    acc_cyc = cyc;
    chk("R1 ready low in flight", int'(start_ready_o), 0);
  endtask

  // end the fetch and check the issue cycle
  task automatic issue_cmd(input int exp_pop, input int exp_pend);
    remaining_nz_i = 1'b0; dma_outstanding_i = 4'd0;
    step();
    chk("R4 issue", int'(cmd_issue_o), 1);
    chk("R4 pop", int'(q_pop_o), exp_pop);
    chk("R5 pend", int'(pend_we_o), exp_pend);
  endtask

  task automatic t_reset();
    chk("R1 reset ready", int'(start_ready_o), 1);
    chk("R9 reset min", int'(lat_min_o), 255);
    chk("R9 reset max", int'(lat_max_o), 0);
    chk("R9 reset sum", int'(lat_sum_o), 0);
    chk("R8 reset disc", int'(disc_cnt_o), 0);
  endtask

  task automatic t_fetch_complete();
    q_nonempty_i = 1'b1; q_head_i = 4'd3;
    start_cmd(4'd3, 8'h52, 8'h00);
    chk("R2 dma_req follows remaining", int'(dma_req_o), 1);
    remaining_nz_i = 1'b0;
    #1 chk("R2 dma_req drops", int'(dma_req_o), 0);
    step();
    chk("R2 wait outstanding", int'(cmd_issue_o), 0);
    issue_cmd(1, 1);
    chk("R5 pend target", int'(pend_tgt_o), 5);
    chk("R5 pend index", int'(pend_idx_o), 3);
    step();
    chk("R6 active polls", int'(retire_o), 0);
    chk("R6 active no ready", int'(start_ready_o), 0);
    tgt_status_i = 3'd2;
    step();
    note_resp();
    tgt_status_i = 3'd0;
    chk("R6 complete retire", int'(retire_o), 1);
    chk("R6 complete no delay", int'(delay_load_o), 0);
    chk("R6 complete idle", int'(start_ready_o), 1);
    chk_lat("complete");
  endtask

  task automatic t_reconnect_abort();
    q_nonempty_i = 1'b1; q_head_i = 4'd7;
    start_cmd(4'd7, 8'h30, 8'h00);
    reconnect_pend_i = 1'b1;
    remaining_nz_i = 1'b0; dma_outstanding_i = 4'd0;
    step();
    reconnect_pend_i = 1'b0;
    chk("R3 no issue", int'(cmd_issue_o), 0);
    chk("R3 no pop", int'(q_pop_o), 0);
    chk("R3 no pend", int'(pend_we_o), 0);
    chk("R3 no retire", int'(retire_o), 0);
    chk("R3 idle", int'(start_ready_o), 1);
    chk_lat("abort");
  endtask

  task automatic t_tagged_error();
    q_nonempty_i = 1'b1; q_head_i = 4'd1;
    start_cmd(4'd2, 8'hA0, 8'h20);
    issue_cmd(0, 0);
    step();
    tgt_status_i = 3'd5;
    step();
    note_resp();
    tgt_status_i = 3'd0;
    chk("R8 error retire", int'(retire_o), 1);
    chk("R8 error delay load", int'(delay_load_o), 1);
    chk("R8 error delay value", int'(delay_val_o), 2);
    chk_lat("error");
  endtask

  task automatic t_busy();
    q_nonempty_i = 1'b0; q_head_i = 4'd4;
    start_cmd(4'd4, 8'h10, 8'h00);
    issue_cmd(0, 1);
    tgt_status_i = 3'd4;
    step();
    note_resp();
    tgt_status_i = 3'd0;
    chk("R7 busy retire", int'(retire_o), 1);
    chk("R7 busy delay load", int'(delay_load_o), 1);
    chk("R7 busy delay value", int'(delay_val_o), 150);
    chk_lat("busy");
  endtask

  task automatic t_resp_disconnect();
    start_cmd(4'd5, 8'h60, 8'h01);
    issue_cmd(0, 1);
    step();
    step();
    tgt_status_i = 3'd3;
    step();
    note_resp();
    exp_disc++;
    tgt_status_i = 3'd0;
    chk("R8 disc no retire", int'(retire_o), 0);
    chk("R8 disc delay load", int'(delay_load_o), 1);
    chk("R8 disc delay value", int'(delay_val_o), 2);
    chk("R8 disc ctrl bit2", int'(ctrl_o), 8'h05);
    chk("R8 disc count", int'(disc_cnt_o), exp_disc);
    chk("R8 disc idle", int'(start_ready_o), 1);
    chk_lat("disc");
  endtask

  task automatic t_data_complete();
    start_cmd(4'd6, 8'h70, 8'h00);
    issue_cmd(0, 1);
    tgt_status_i = 3'd1;
    step();
    note_resp();
    chk("R6 connect no retire", int'(retire_o), 0);
    chk("R6 connect busy", int'(start_ready_o), 0);
    chk_lat("connect");
    remaining_nz_i = 1'b1;
    #1 chk("R2 data dma_req", int'(dma_req_o), 1);
    step();
    chk("R10 connect polls", int'(retire_o), 0);
    remaining_nz_i = 1'b0; dma_outstanding_i = 4'd2; tgt_status_i = 3'd2;
    step();
    chk("R10 waits outstanding", int'(retire_o), 0);
    dma_outstanding_i = 4'd0;
    step();
    tgt_status_i = 3'd0;
    chk("R10 complete retire", int'(retire_o), 1);
    chk("R10 complete idle", int'(start_ready_o), 1);
    chk_lat("data");
  endtask

  task automatic t_data_disconnect();
    start_cmd(4'd8, 8'h80, 8'h00);
    issue_cmd(0, 1);
    tgt_status_i = 3'd1;
    step();
    note_resp();
    tgt_status_i = 3'd3;
    step();
    tgt_status_i = 3'd0;
    chk("R10 disc no retire", int'(retire_o), 0);
    chk("R10 disc delay value", int'(delay_val_o), 2);
    chk("R10 disc delay load", int'(delay_load_o), 1);
    chk("R10 disc count unchanged", int'(disc_cnt_o), exp_disc);
    chk("R10 disc idle", int'(start_ready_o), 1);
    chk_lat("data disc");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_fetch_complete();
    t_reconnect_abort();
    t_tagged_error();
    t_busy();
    t_resp_disconnect();
    t_data_complete();
    t_data_disconnect();
    chk("err flag clear", int'(err_o), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule